// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block is the device side of a byte-wide parallel flash part, written as synthesizable logic that runs on a fast internal clock. The chip-enable, output-enable and write-enable strobes, the 19-bit address and the 8-bit data bus are registered on that clock. Edges of the combined write strobe (the OR of chip enable and write enable) are detected from the registered values. The address is taken where the combined strobe falls, which is where the later of the two lines goes low. The data is taken where the combined strobe rises, which is where the earlier of the two lines goes high.

The completed write cycles go to a sequence decoder. It accepts three unlock-gated commands: byte program, sector erase and chip erase. The decoder starts an internal operation on a small on-chip array. Each operation lasts a parameterised number of clock cycles. While an operation runs, every write cycle is dropped. A read during that time returns a status byte in place of array data, so that a host can poll for completion. When the device is idle, a read returns the array byte.

The bidirectional data pins are split into an input, an output and an output-enable. The output-enable low stands for a high-impedance bus. The strobes are plain control pins with no flow control.

Top module: `pflash_cmd_dec`

## Requirements
- R1: The address of a write cycle is the value present when the later of ce_n and we_n falls. The data is the value present when the earlier of the two rises. Both WE-controlled and CE-controlled cycles are accepted.
- R2: dq_oe is high, one clock after the inputs, only while ce_n and oe_n are both low. When the device is idle, dq_o then holds the array byte at addr[MEM_AW-1:0]. After reset, every array byte reads FFh.
- R3: Byte program is the sequence AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h, then the data at the target address. Unlock addresses are compared on addr[14:0] only. The operation starts when the fourth cycle ends and keeps busy high for PROG_CYC cycles.
- R4: Sector erase is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 20h at any address in the sector. On completion, every byte whose address bits [MEM_AW-1:7] match the sector is FFh, and all other bytes are unchanged.
- R5: Chip erase is the same five cycles followed by 10h at an address whose bits [10:0] equal 555h. On completion, every byte is FFh. A last cycle of 10h at any other address does nothing.
- R6: A program stores the old byte ANDed with the written data, so bits only ever go from 1 to 0.
- R7: A write cycle that ends while busy is high is ignored. It neither starts an operation nor advances a sequence.
- R8: While busy, a read returns a status byte. Bit 7 is the complement of bit 7 of the data being programmed, or 0 during an erase. Bit 6 inverts after each completed read. Bits 5:0 are 0.
- R9: A cycle that does not match the expected step of a sequence returns the decoder to idle. The array is left unchanged.
- R10: op_done pulses for exactly one cycle when an operation completes. busy is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW (19) | Byte address |
| dq_i | input | 8 | Data bus input side |
| dq_o | output | 8 | Data bus output side: array byte or status |
| dq_oe | output | 1 | Data bus drive enable; low means high impedance |
| busy | output | 1 | Internal operation running |
| op_done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same cycle. The first is the completion of an internal operation. The second is host bus traffic: a polling read, or a write cycle issued while the operation is still running. The bench provokes the first case by reading status back-to-back right after each command, and then reading the same byte once busy falls. It judges each read against the expected status byte or the arithmetically computed array byte. It provokes the second case by issuing a whole program sequence inside a running program, then sweeping the array and counting op_done pulses. This shows the late sequence neither altered a byte nor produced a completion.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PGM,
    SQ_ERS3,
    SQ_ERS4,
    SQ_ERS5
  } seq_st_t;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_PROG,
    OP_SECT,
    OP_CHIP
  } op_kind_t;

  localparam int UNLOCK_W = 15;
  localparam int CHIPA_W  = 11;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_SECT   = 8'h20;
  localparam logic [7:0] CMD_CHIP   = 8'h10;

  localparam logic [UNLOCK_W-1:0] ADR_FIRST  = 15'h5555;
  localparam logic [UNLOCK_W-1:0] ADR_SECOND = 15'h2AAA;
  localparam logic [CHIPA_W-1:0]  ADR_CHIP   = 11'h555;

endpackage

// File: rtl/pflash_bus_sampler.sv
module pflash_bus_sampler #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dq_i,
  output logic          wr_pulse,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_en,
  output logic          rd_end,
  output logic [AW-1:0] rd_addr
);

  logic          s_ce, s_we, s_oe;
  logic [AW-1:0] s_addr;
  logic [7:0]    s_dat, p_dat;
  logic          p_str, p_rd;
  logic          str_now;

  assign str_now = s_ce | s_we;
  assign rd_en   = ~s_ce & ~s_oe;
  assign rd_end  = p_rd & ~rd_en;
  assign rd_addr = s_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ce     <= 1'b1;
      s_we     <= 1'b1;
      s_oe     <= 1'b1;
      s_addr   <= '0;
      s_dat    <= '0;
      p_dat    <= '0;
      p_str    <= 1'b1;
      p_rd     <= 1'b0;
      wr_pulse <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      s_ce   <= ce_n;
      s_we   <= we_n;
      s_oe   <= oe_n;
      s_addr <= addr;
      s_dat  <= dq_i;
      p_dat  <= s_dat;
      p_str  <= str_now;
      p_rd   <= rd_en;
      // combined strobe fell: the later of the two lines just went low
      if (p_str && !str_now) wr_addr <= s_addr;
      // combined strobe rose: keep the data seen while it was still low
      wr_pulse <= ~p_str & str_now;
      if (!p_str && str_now) wr_data <= p_dat;
    end
  end

endmodule

// File: rtl/pflash_seq_decoder.sv
module pflash_seq_decoder
  import pflash_pkg::*;
#(
  parameter int MEM_AW = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_pulse,
  input  logic [UNLOCK_W-1:0] wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                busy,
  output logic                start,
  output op_kind_t            start_kind,
  output logic [MEM_AW-1:0]   start_addr,
  output logic [7:0]          start_data
);

  seq_st_t st_q;
  logic    hit_first, hit_second, hit_prog, hit_erase, hit_chip_adr;

  assign hit_first    = (wr_data == KEY_FIRST)  && (wr_addr == ADR_FIRST);
  assign hit_second   = (wr_data == KEY_SECOND) && (wr_addr == ADR_SECOND);
  assign hit_prog     = (wr_data == CMD_PROG)   && (wr_addr == ADR_FIRST);
  assign hit_erase    = (wr_data == CMD_ERASE)  && (wr_addr == ADR_FIRST);
  assign hit_chip_adr = (wr_addr[CHIPA_W-1:0] == ADR_CHIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SQ_IDLE;
      start      <= 1'b0;
      start_kind <= OP_NONE;
      start_addr <= '0;
      start_data <= '0;
    end else begin
      start <= 1'b0;
      if (wr_pulse && !busy) begin
        st_q <= SQ_IDLE;
        unique case (st_q)
          SQ_IDLE: if (hit_first)  st_q <= SQ_UNL1;
          SQ_UNL1: if (hit_second) st_q <= SQ_UNL2;
          SQ_UNL2: begin
            if (hit_prog)       st_q <= SQ_PGM;
            else if (hit_erase) st_q <= SQ_ERS3;
          end
          SQ_PGM: begin
            start      <= 1'b1;
            start_kind <= OP_PROG;
            start_addr <= wr_addr[MEM_AW-1:0];
            start_data <= wr_data;
          end
          SQ_ERS3: if (hit_first)  st_q <= SQ_ERS4;
          SQ_ERS4: if (hit_second) st_q <= SQ_ERS5;
          SQ_ERS5: begin
            if (wr_data == CMD_SECT) begin
              start      <= 1'b1;
              start_kind <= OP_SECT;
              start_addr <= wr_addr[MEM_AW-1:0];
            end else if (wr_data == CMD_CHIP && hit_chip_adr) begin
              start      <= 1'b1;
              start_kind <= OP_CHIP;
              start_addr <= wr_addr[MEM_AW-1:0];
            end
          end
          default: st_q <= SQ_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/pflash_array_engine.sv
module pflash_array_engine
  import pflash_pkg::*;
#(
  parameter int MEM_AW   = 9,
  parameter int SECT_AW  = 7,
  parameter int PROG_CYC = 40,
  parameter int SECT_CYC = 80,
  parameter int CHIP_CYC = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_kind_t          start_kind,
  input  logic [MEM_AW-1:0] start_addr,
  input  logic [7:0]        start_data,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic              st_bit7
);

  localparam int DEPTH  = 1 << MEM_AW;
  localparam int MAX_AB = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_C  = (MAX_AB > CHIP_CYC) ? MAX_AB : CHIP_CYC;
  localparam int CW     = $clog2(MAX_C + 1);

  logic [7:0]        mem [DEPTH];
  op_kind_t          kind_q;
  logic [MEM_AW-1:0] tgt_q;
  logic [7:0]        dat_q;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     len_m1;
  logic              finish;

  always_comb begin
    unique case (start_kind)
      OP_SECT: len_m1 = CW'(SECT_CYC - 1);
      OP_CHIP: len_m1 = CW'(CHIP_CYC - 1);
      default: len_m1 = CW'(PROG_CYC - 1);
    endcase
  end

  assign finish  = busy && (cnt_q == '0);
  assign rd_data = mem[rd_addr];
  assign st_bit7 = (kind_q == OP_PROG) ? ~dat_q[7] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      kind_q <= OP_NONE;
      tgt_q  <= '0;
      dat_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (start) begin
        busy   <= 1'b1;
        kind_q <= start_kind;
        tgt_q  <= start_addr;
        dat_q  <= start_data;
        cnt_q  <= len_m1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (finish) begin
      unique case (kind_q)
        OP_PROG: mem[tgt_q] <= mem[tgt_q] & dat_q;
        OP_SECT: begin
          for (int i = 0; i < DEPTH; i++)
            if ((MEM_AW'(i) >> SECT_AW) == (tgt_q >> SECT_AW)) mem[i] <= 8'hFF;
        end
        OP_CHIP: begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pflash_read_path.sv
module pflash_read_path (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       rd_end,
  input  logic       busy,
  input  logic       st_bit7,
  input  logic [7:0] arr_data,
  output logic [7:0] dq_o,
  output logic       dq_oe
);

  logic tog_q;

  // toggles after each finished read, so the value is steady within a read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tog_q <= 1'b0;
    else if (!busy)   tog_q <= 1'b0;
    else if (rd_end)  tog_q <= ~tog_q;
  end

  assign dq_oe = rd_en;
  assign dq_o  = busy ? {st_bit7, tog_q, 6'b0} : arr_data;

endmodule

// File: rtl/pflash_cmd_dec.sv
module pflash_cmd_dec
  import pflash_pkg::*;
#(
  parameter int AW       = 19,
  parameter int MEM_AW   = 9,
  parameter int SECT_AW  = 7,
  parameter int PROG_CYC = 40,
  parameter int SECT_CYC = 80,
  parameter int CHIP_CYC = 120
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dq_i,
  output logic [7:0]    dq_o,
  output logic          dq_oe,
  output logic          busy,
  output logic          op_done
);

  logic              wr_pulse, rd_en, rd_end, st_bit7, seq_start;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [7:0]        wr_data, arr_data, start_data;
  logic [MEM_AW-1:0] start_addr;
  op_kind_t          start_kind;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^{wr_addr[AW-1:UNLOCK_W], rd_addr[AW-1:MEM_AW]};

  pflash_bus_sampler #(.AW(AW)) u_smp (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_i(dq_i), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_end(rd_end), .rd_addr(rd_addr)
  );

  pflash_seq_decoder #(.MEM_AW(MEM_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse),
    .wr_addr(wr_addr[UNLOCK_W-1:0]), .wr_data(wr_data), .busy(busy),
    .start(seq_start), .start_kind(start_kind), .start_addr(start_addr),
    .start_data(start_data)
  );

  pflash_array_engine #(
    .MEM_AW(MEM_AW), .SECT_AW(SECT_AW), .PROG_CYC(PROG_CYC),
    .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .start_kind(start_kind),
    .start_addr(start_addr), .start_data(start_data),
    .rd_addr(rd_addr[MEM_AW-1:0]), .rd_data(arr_data), .busy(busy),
    .done(op_done), .st_bit7(st_bit7)
  );

  pflash_read_path u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_end(rd_end), .busy(busy),
    .st_bit7(st_bit7), .arr_data(arr_data), .dq_o(dq_o), .dq_oe(dq_oe)
  );

endmodule

// File: rtl/pflash_cmd_dec_chk.sv
module pflash_cmd_dec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic [7:0] dq_o,
  input logic       dq_oe,
  input logic       busy,
  input logic       op_done,
  input logic       seq_start
);

  // R2: the bus is driven only after both enables were low
  a_r2_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!ce_n && !oe_n));

  // R2: either enable high releases the bus on the next cycle
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |=> !dq_oe);

  // R7: no operation is launched while one is running
  a_r7_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !seq_start);

  // R8: low status bits stay clear while busy
  a_r8_status_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dq_oe) |-> (dq_o[5:0] == 6'b0));

  // R10: completion pulse lasts a single cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  // R10: completion ends a busy period
  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> ($past(busy) && !busy));

endmodule

bind pflash_cmd_dec pflash_cmd_dec_chk u_chk (.*);

// File: tb/tb_pflash_cmd_dec.sv
`timescale 1ns/1ps
module tb_pflash_cmd_dec;

  localparam int AW = 19, MEM_AW = 9, DEPTH = 512;
  localparam int PROG_CYC = 150, SECT_CYC = 200, CHIP_CYC = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] dq_i = '0;
  logic [7:0] dq_o;
  logic dq_oe, busy, op_done;

  int n_chk = 0, n_fail = 0, n_done = 0, n_wide = 0, exp_done = 0;
  bit fin = 1'b0, prev_done = 1'b0;
  logic [7:0] model [DEPTH];

  always #4 clk = ~clk;

  pflash_cmd_dec #(.AW(AW), .MEM_AW(MEM_AW), .PROG_CYC(PROG_CYC),
    .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .busy(busy),
    .op_done(op_done));

  always @(posedge clk) begin
    if (op_done) n_done++;
    if (op_done && prev_done) n_wide++;
    prev_done = op_done;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // the later-falling strobe is the one that also rises first
  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d, input bit ce_ctl);
    addr = ~a; dq_i = ~d;
    if (ce_ctl) we_n = 1'b0; else ce_n = 1'b0;
    tick(2); addr = a; tick(2);
    if (ce_ctl) ce_n = 1'b0; else we_n = 1'b0;
    tick(3); addr = ~a; dq_i = d; tick(3);
    if (ce_ctl) ce_n = 1'b1; else we_n = 1'b1;
    tick(1); dq_i = ~d; tick(1);
    if (ce_ctl) we_n = 1'b1; else ce_n = 1'b1;
    tick(3);
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] v, output logic oe);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    tick(3); v = dq_o; oe = dq_oe;
    oe_n = 1'b1; ce_n = 1'b1; tick(2);
  endtask

  task automatic unlock(input bit ctl);
    bus_wr(19'h05555, 8'hAA, ctl);
    bus_wr(19'h02AAA, 8'h55, ctl);
  endtask

  task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d, input bit ctl);
    unlock(ctl);
    bus_wr(19'h45555, 8'hA0, ctl);
    bus_wr(a, d, ctl);
  endtask

  task automatic erase_seq(input logic [AW-1:0] a, input logic [7:0] cmd);
    unlock(1'b0);
    bus_wr(19'h05555, 8'h80, 1'b0);
    unlock(1'b1);
    bus_wr(a, cmd, 1'b1);
  endtask

  task automatic wait_idle();
    while (busy) tick(1);
    tick(2);
  endtask

  task automatic sweep(input string req);
    logic [7:0] v; logic oe;
    for (int i = 0; i < DEPTH; i++) begin
      bus_rd(AW'(i), v, oe);
      chk(oe && v == model[i], req, {oe, v}, {1'b1, model[i]});
    end
  endtask

  task automatic status_pair(input logic [AW-1:0] a, input logic b7, input string req);
    logic [7:0] v1, v2; logic o1, o2;
    bus_rd(a, v1, o1);
    bus_rd(a, v2, o2);
    chk(busy && o1 && v1[7] == b7 && v1[5:0] == 0, req, {o1, v1}, {1'b1, b7, v1[6], 6'b0});
    chk(o2 && v2[6] != v1[6] && v2[7] == b7, {req, " toggle"}, v2, {b7, ~v1[6], 6'b0});
  endtask

  initial begin
    logic [7:0] v; logic oe;
    logic [AW-1:0] a; logic [7:0] d;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    tick(5); rst_n = 1'b1; tick(3);

    // reset state
    chk(!dq_oe && !busy && !op_done, "R2/R10 reset", {dq_oe, busy, op_done}, 0);
    sweep("R2 erased after reset");

    // R2: one enable alone never drives the bus
    addr = 19'h00010; ce_n = 1'b0; tick(3);
    chk(!dq_oe, "R2 ce only", dq_oe, 0);
    ce_n = 1'b1; oe_n = 1'b0; tick(3);
    chk(!dq_oe, "R2 oe only", dq_oe, 0);
    oe_n = 1'b1; tick(2);

    // R1/R3/R6/R8: programs in both strobe styles, with status polling
    for (int k = 0; k < 16; k++) begin
      a = AW'((k * 43 + 5) % DEPTH);
      d = 8'((k * 29 + 3) ^ (k << 5));
      if (k >= 12) begin
        a = AW'(((k - 12) * 43 + 5) % DEPTH);
        d = 8'h5A ^ 8'(k);
      end
      do_prog(a, d, k[0]);
      exp_done++;
      status_pair(a, ~d[7], "R8 program status");
      wait_idle();
      model[a[MEM_AW-1:0]] = model[a[MEM_AW-1:0]] & d;
      bus_rd(a, v, oe);
      chk(oe && v == model[a[MEM_AW-1:0]], "R1/R3/R6 program result", v, model[a[MEM_AW-1:0]]);
    end
    chk(n_done == exp_done && n_wide == 0, "R10 done pulses", n_done, exp_done);

    // R7: a whole program sequence during a running program is dropped
    do_prog(19'h00100, 8'h0F, 1'b0);
    exp_done++;
    do_prog(19'h00101, 8'h00, 1'b1);
    chk(busy, "R7 still busy after late sequence", busy, 1);
    wait_idle();
    model[9'h100] = model[9'h100] & 8'h0F;
    bus_rd(19'h00101, v, oe);
    chk(v == model[9'h101], "R7 ignored write", v, model[9'h101]);
    chk(n_done == exp_done, "R7/R10 one completion only", n_done, exp_done);

    // R9: wrong command byte, then wrong unlock address
    unlock(1'b0);
    bus_wr(19'h05555, 8'h33, 1'b0);
    bus_wr(19'h00102, 8'h00, 1'b0);
    tick(4);
    chk(!busy, "R9 bad command no start", busy, 0);
    bus_wr(19'h05555, 8'hAA, 1'b1);
    bus_wr(19'h02AAB, 8'h55, 1'b1);
    bus_wr(19'h05555, 8'hA0, 1'b1);
    bus_wr(19'h00102, 8'h00, 1'b1);
    tick(4);
    chk(!busy, "R9 bad unlock no start", busy, 0);
    bus_rd(19'h00102, v, oe);
    chk(v == model[9'h102], "R9 array unchanged", v, model[9'h102]);
    chk(n_done == exp_done, "R9 no completion", n_done, exp_done);

    // R4: sector erase of sector 1 (bits [8:7] = 01)
    erase_seq(19'h000C3, 8'h20);
    exp_done++;
    status_pair(19'h000C3, 1'b0, "R8 erase status");
    wait_idle();
    for (int i = 128; i < 256; i++) model[i] = 8'hFF;
    sweep("R4 sector erase");

    // R5: chip erase at a wrong address is dropped
    erase_seq(19'h00556, 8'h10);
    tick(4);
    chk(!busy, "R5 wrong chip address", busy, 0);
    sweep("R5 array kept");

    // R5: chip erase with bits [10:0] = 555h
    erase_seq(19'h70555, 8'h10);
    exp_done++;
    status_pair(19'h00000, 1'b0, "R8 chip erase status");
    wait_idle();
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    sweep("R5 chip erase");
    chk(n_done == exp_done && n_wide == 0, "R10 final done count", n_done, exp_done);

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule